// File: doc/BRIEF.md
# Two-Entry Bus Target Write Buffer

This block sits between the write side of a bus target and a local agent that consumes the written words. Each write data phase on the bus offers one word with its byte-enable mask. The block stores accepted words in a two-slot queue. The local side sees the oldest stored word at its outputs and removes it by pulsing a ready strobe.

In the same cycle that a data phase is offered, the block decides whether to take it, to hold the bus in wait, or to ask the initiator to retry. An access may begin only when both slots are empty. Because of that rule, the opening two phases of any access always fit and are taken at once. Starting with the third phase, a word is taken as soon as a slot is free. That slot may be the one being freed in that same cycle. If no slot frees up within a fixed window of wait cycles, the block answers with retry and the access ends.

An attention flag tells the local side that it has work to do. The flag stays up while an access is open and while any stored word remains. After a retry, the flag therefore stays high until every word left behind has been drained.

Top module: `twb_top`

## Requirements
- R1: After synchronous reset, `loc_attn`, `bus_accept` and `bus_retry` are all low and the queue holds no word.
- R2: A data phase with `bus_start` high offered while the queue is empty is accepted in the same cycle. The next phase of that access is also accepted in its own cycle, with no wait.
- R3: Within an access that was accepted at its start, `bus_retry` is never given on the first or second data phase. It can be given only on the third phase or a later one.
- R4: From the third phase onward, a phase offered while both slots are full is held with neither `bus_accept` nor `bus_retry`. It is accepted in the first cycle in which a slot is free or being freed by `loc_rdy`. If it is still unaccepted in its `RETRY_WAIT`-th cycle (default 8), `bus_retry` is given in that cycle and the access ends.
- R5: `bus_retry` is given, and nothing is stored, in two cases: a phase with `bus_start` high offered while any word is held, and a phase with `bus_start` low offered when no access is open.
- R6: Words leave in arrival order. `loc_data` and `loc_be` show the oldest word. Bit i of the byte-enable mask covers data bits 8i+7..8i and is returned unchanged with its own word.
- R7: An accept and a `loc_rdy` removal in the same cycle leave the occupancy unchanged, and the queue order is kept.
- R8: `loc_attn` is high from the clock edge after an access opens until it closes, and it stays high while any word is held. After a retry with two words held, it falls at the clock edge that samples the second `loc_rdy` pulse.
- R9: `loc_rdy` while the queue is empty has no effect. The next accepted word appears at `loc_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A write data phase is offered this cycle |
| bus_start | input | 1 | The offered phase opens a new access |
| bus_last | input | 1 | The offered phase is the final one of its access |
| bus_wdata | input | DW | Write data of the offered phase |
| bus_wbe | input | BW | Byte enables of the offered phase |
| bus_accept | output | 1 | The offered phase is taken this cycle |
| bus_retry | output | 1 | The offered phase is refused; the access ends |
| loc_rdy | input | 1 | Local side has read the head word; remove it |
| loc_attn | output | 1 | Access open or words pending (registered) |
| loc_data | output | DW | Data of the oldest stored word |
| loc_be | output | BW | Byte enables of the oldest stored word |

## Verification
The assertions assume that the bus keeps a held phase offered, with `bus_valid` high, until it receives an accept or a retry. They also assume that `bus_start` is raised only on a phase that opens a new access. The bench drives every phase as a single task step and repeats a held phase with the same values on each cycle until one of the two answers appears. It raises `loc_rdy` only at points where the expected occupancy is known. The single deliberate pulse on an empty queue is there to check that it is ignored.

// File: rtl/twb_pkg.sv
package twb_pkg;
  localparam int TWB_DW_DEF   = 32;
  localparam int TWB_WAIT_DEF = 8;
  localparam int TWB_SLOTS    = 2;

  typedef enum logic [1:0] {
    DEC_IDLE   = 2'd0,
    DEC_ACCEPT = 2'd1,
    DEC_RETRY  = 2'd2,
    DEC_STALL  = 2'd3
  } twb_dec_t;
endpackage

// File: rtl/twb_store.sv
module twb_store #(
  parameter int DW    = 32,
  parameter int BW    = DW / 8,
  parameter int DEPTH = 2,
  localparam int EW   = DW + BW,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic [BW-1:0] push_be,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic [BW-1:0] head_be,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic          empty,
  output logic          full,
  output logic          pop_fire
);
  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;
  logic [EW-1:0] head_word;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty     = (count_q == '0);
  assign full      = (count_q == CW'(DEPTH));
  assign pop_fire  = pop && !empty;
  assign count     = count_q;
  assign count_nxt = count_q + CW'(push) - CW'(pop_fire);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {push_be, push_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push)     wr_ptr <= ptr_inc(wr_ptr);
      if (pop_fire) rd_ptr <= ptr_inc(rd_ptr);
      count_q <= count_nxt;
    end
  end

  assign head_word = mem[rd_ptr];
  assign head_data = head_word[DW-1:0];
  assign head_be   = head_word[EW-1:DW];

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push && full) |-> pop_fire);
  a_r9_empty_pop_ignored: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> (count == '0));
  a_r7_occupancy_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/twb_gate.sv
module twb_gate
  import twb_pkg::*;
#(
  parameter int RETRY_WAIT = 8,
  localparam int WW = $clog2(RETRY_WAIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_valid,
  input  logic bus_start,
  input  logic bus_last,
  input  logic buf_empty,
  input  logic buf_full,
  input  logic pop_fire,
  output logic accept,
  output logic retry,
  output logic open_q,
  output logic open_nxt
);
  twb_dec_t      dec;
  logic [1:0]    idx_q;
  logic [WW-1:0] wait_q;
  logic          space;

  assign space = !buf_full || pop_fire;

  always_comb begin
    dec = DEC_IDLE;
    if (bus_valid) begin
      if (bus_start) begin
        dec = buf_empty ? DEC_ACCEPT : DEC_RETRY;
      end else if (open_q) begin
        if (idx_q < 2'd2 || space)                 dec = DEC_ACCEPT;
        else if (wait_q == WW'(RETRY_WAIT - 1))    dec = DEC_RETRY;
        else                                       dec = DEC_STALL;
      end else begin
        dec = DEC_RETRY;
      end
    end
  end

  assign accept = (dec == DEC_ACCEPT);
  assign retry  = (dec == DEC_RETRY);

  always_comb begin
    open_nxt = open_q;
    if (accept)     open_nxt = !bus_last;
    else if (retry) open_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      idx_q  <= '0;
      wait_q <= '0;
    end else begin
      open_q <= open_nxt;
      case (dec)
        DEC_ACCEPT: begin
          wait_q <= '0;
          if (bus_start)           idx_q <= 2'd1;
          else if (idx_q != 2'd2)  idx_q <= idx_q + 2'd1;
        end
        DEC_RETRY: begin
          wait_q <= '0;
          idx_q  <= '0;
        end
        DEC_STALL: wait_q <= wait_q + WW'(1);
        default: ;
      endcase
    end
  end

  a_r3_retry_late_only: assert property (@(posedge clk) disable iff (rst)
    (retry && !bus_start && open_q) |-> (idx_q == 2'd2));
  a_r4_wait_bounded: assert property (@(posedge clk) disable iff (rst)
    wait_q <= WW'(RETRY_WAIT - 1));
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !accept && !retry) |=> (bus_valid && !bus_start));
  a_r5_answers_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(accept && retry));
endmodule

// File: rtl/twb_attn.sv
module twb_attn (
  input  logic clk,
  input  logic rst,
  input  logic open_nxt,
  input  logic held_nxt,
  output logic attn
);
  always_ff @(posedge clk) begin
    if (rst) attn <= 1'b0;
    else     attn <= open_nxt || held_nxt;
  end
endmodule

// File: rtl/twb_top.sv
module twb_top #(
  parameter int DW         = twb_pkg::TWB_DW_DEF,
  parameter int BW         = DW / 8,
  parameter int RETRY_WAIT = twb_pkg::TWB_WAIT_DEF,
  localparam int DEPTH     = twb_pkg::TWB_SLOTS,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic          bus_start,
  input  logic          bus_last,
  input  logic [DW-1:0] bus_wdata,
  input  logic [BW-1:0] bus_wbe,
  output logic          bus_accept,
  output logic          bus_retry,
  input  logic          loc_rdy,
  output logic          loc_attn,
  output logic [DW-1:0] loc_data,
  output logic [BW-1:0] loc_be
);
  logic          buf_empty, buf_full, pop_fire;
  logic [CW-1:0] count, count_nxt;
  logic          open_q, open_nxt;

  twb_store #(.DW(DW), .BW(BW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .push(bus_accept), .push_data(bus_wdata), .push_be(bus_wbe),
    .pop(loc_rdy),
    .head_data(loc_data), .head_be(loc_be),
    .count(count), .count_nxt(count_nxt),
    .empty(buf_empty), .full(buf_full), .pop_fire(pop_fire)
  );

  twb_gate #(.RETRY_WAIT(RETRY_WAIT)) u_gate (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_start(bus_start), .bus_last(bus_last),
    .buf_empty(buf_empty), .buf_full(buf_full), .pop_fire(pop_fire),
    .accept(bus_accept), .retry(bus_retry),
    .open_q(open_q), .open_nxt(open_nxt)
  );

  twb_attn u_attn (
    .clk(clk), .rst(rst),
    .open_nxt(open_nxt), .held_nxt(count_nxt != '0),
    .attn(loc_attn)
  );

  a_r2_empty_start_taken: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_start && buf_empty) |-> bus_accept);
  a_r5_busy_start_refused: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_start && !buf_empty) |-> (bus_retry && !bus_accept));
  a_r8_attn_while_held: assert property (@(posedge clk) disable iff (rst)
    (count != '0 && !pop_fire) |=> loc_attn);
  a_r8_attn_while_open: assert property (@(posedge clk) disable iff (rst)
    (bus_accept && !bus_last) |=> loc_attn);
  a_r1_idle_answers: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |-> (!bus_accept && !bus_retry));
endmodule

// File: tb/twb_top_bench.sv
module twb_top_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_valid, bus_start, bus_last, loc_rdy;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_wbe;
  logic        bus_accept, bus_retry, loc_attn;
  logic [31:0] loc_data;
  logic [3:0]  loc_be;
  int checks = 0;
  int errors = 0;
  logic acc_s, rty_s;

  always #2 clk = ~clk;

  twb_top u_twb_top (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_start(bus_start), .bus_last(bus_last),
    .bus_wdata(bus_wdata), .bus_wbe(bus_wbe),
    .bus_accept(bus_accept), .bus_retry(bus_retry),
    .loc_rdy(loc_rdy), .loc_attn(loc_attn),
    .loc_data(loc_data), .loc_be(loc_be)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic s, input logic l,
                      input logic [31:0] d, input logic [3:0] be, input logic rdy);
    bus_valid = v; bus_start = s; bus_last = l;
    bus_wdata = d; bus_wbe = be; loc_rdy = rdy;
    #1;
    acc_s = bus_accept;
    rty_s = bus_retry;
    @(negedge clk);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 attn", {63'h0, loc_attn}, 64'h0);
    idle();
    check("R1 accept", {63'h0, acc_s}, 64'h0);
    check("R1 retry", {63'h0, rty_s}, 64'h0);
  endtask

  task automatic t_retry_drain();
    step(1, 1, 0, 32'hA000_000A, 4'hF, 0);
    check("R2 first phase", {63'h0, acc_s}, 64'h1);
    step(1, 0, 0, 32'hB000_000B, 4'h3, 0);
    check("R2 second phase", {63'h0, acc_s}, 64'h1);
    for (int k = 0; k < 8; k++) begin
      step(1, 0, 0, 32'hC000_000C, 4'h1, 0);
      if (k < 7) check("R4 held no answer", {62'h0, acc_s, rty_s}, 64'h0);
      else       check("R3 R4 late retry", {62'h0, acc_s, rty_s}, 64'h1);
    end
    check("R8 attn after retry", {63'h0, loc_attn}, 64'h1);
    check("R6 head data", {32'h0, loc_data}, 64'hA000_000A);
    step(1, 1, 1, 32'hEEEE_EEEE, 4'h8, 0);
    check("R5 busy start", {62'h0, acc_s, rty_s}, 64'h1);
    check("R5 nothing stored", {28'h0, loc_be, loc_data}, {28'h0, 4'hF, 32'hA000_000A});
    step(0, 0, 0, 0, 0, 1);
    check("R6 second word", {28'h0, loc_be, loc_data}, {28'h0, 4'h3, 32'hB000_000B});
    check("R8 attn one left", {63'h0, loc_attn}, 64'h1);
    step(0, 0, 0, 0, 0, 1);
    check("R8 attn falls on second rdy", {63'h0, loc_attn}, 64'h0);
  endtask

  task automatic t_wait_accept();
    step(1, 1, 0, 32'h1111_0001, 4'h1, 0);
    step(1, 0, 0, 32'h2222_0002, 4'h2, 0);
    for (int k = 0; k < 4; k++) begin
      step(1, 0, 1, 32'h3333_0003, 4'h4, (k == 3));
      if (k < 3) check("R4 stall", {62'h0, acc_s, rty_s}, 64'h0);
      else       check("R4 R7 accept on freed slot", {62'h0, acc_s, rty_s}, 64'h2);
    end
    check("R7 order after swap", {28'h0, loc_be, loc_data}, {28'h0, 4'h2, 32'h2222_0002});
    step(0, 0, 0, 0, 0, 1);
    check("R7 third word", {28'h0, loc_be, loc_data}, {28'h0, 4'h4, 32'h3333_0003});
    check("R8 attn pending", {63'h0, loc_attn}, 64'h1);
    step(0, 0, 0, 0, 0, 1);
    check("R8 attn drained", {63'h0, loc_attn}, 64'h0);
  endtask

  task automatic t_empty_rdy();
    step(0, 0, 0, 0, 0, 1);
    check("R9 attn stays low", {63'h0, loc_attn}, 64'h0);
    step(1, 1, 1, 32'hD00D_F00D, 4'h9, 0);
    check("R2 single phase", {63'h0, acc_s}, 64'h1);
    check("R9 next word at head", {28'h0, loc_be, loc_data}, {28'h0, 4'h9, 32'hD00D_F00D});
    step(0, 0, 0, 0, 0, 1);
    check("R8 attn off", {63'h0, loc_attn}, 64'h0);
  endtask

  task automatic t_open_access();
    step(1, 0, 0, 32'h5, 4'h1, 0);
    check("R5 stray phase", {62'h0, acc_s, rty_s}, 64'h1);
    step(1, 1, 0, 32'h6, 4'h1, 0);
    step(0, 0, 0, 0, 0, 1);
    check("R8 attn while open and empty", {63'h0, loc_attn}, 64'h1);
    step(1, 0, 1, 32'h7, 4'h1, 0);
    check("R2 closing phase", {63'h0, acc_s}, 64'h1);
    step(0, 0, 0, 0, 0, 1);
    check("R8 attn after close", {63'h0, loc_attn}, 64'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    bus_valid = 0; bus_start = 0; bus_last = 0;
    bus_wdata = 0; bus_wbe = 0; loc_rdy = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_retry_drain();
    t_wait_accept();
    t_empty_rdy();
    t_open_access();
    idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule